// File: doc/BRIEF.md
# Two-Line Pixel Delay Memory

This block buffers scanned image lines so that a vertical filter can see three rows at once. Pixels arrive one per write clock and are stored in a near bank. A separate, unrelated read clock walks a read address through the same positions. On every enabled read edge the block does three things. It returns the near-bank word, which is one line old. It returns the far-bank word, which is two lines old. It copies the near-bank word into the far bank so that the far bank stays one line behind the near bank.

Each side has an active-low step enable and an active-low address clear, both sampled on that side's clock. The line length follows from the spacing of the clear pulses, or from the counters wrapping at `DEPTH`. A delay shorter than a line comes from clearing the two sides some cycles apart, or from pausing the read side. The outputs are registered and come with a valid flag. The flag is low while the read side is paused or cleared. It is also low for a guard interval after a pause during which new words were written, because the first words read after such a pause may be stale.

Top module: `lb2_line_delay`

## Requirements
- R1: A write clock edge with `wr_clr_n` high and `wr_hold_n` low stores `wr_pix` at the current write address in the near bank, then advances the write address by one.
- R2: A write clock edge with `wr_hold_n` high stores nothing, and the write address keeps its value.
- R3: A read clock edge with `rd_clr_n` high and `rd_hold_n` low does the following. It loads `pix_1l` from the near bank and `pix_2l` from the far bank at the read address. It copies that near-bank word into the far bank at the same address. It then advances the read address. As a result, with both sides running in step, `pix_1l` is the pixel written one line earlier and `pix_2l` the pixel written two lines earlier.
- R4: A read clock edge with `rd_hold_n` high leaves the read address, the far bank, `pix_1l` and `pix_2l` unchanged, and drives `pix_vld` low after that edge.
- R5: A write clock edge that samples `wr_clr_n` low sets the write address to 0 and stores nothing.
- R6: A read clock edge that samples `rd_clr_n` low sets the read address to 0, moves no data, and drives `pix_vld` low.
- R7: Both address counters go from `DEPTH-1` back to 0.
- R8: Consider a read pause during which a write reaches the read domain through the `SYNC`-stage synchronizer. The first `GUARD` enabled read edges after that pause leave `pix_vld` low. Later enabled edges set it high.
- R9: After a read pause with no writes, the first enabled read edge sets `pix_vld` high.
- R10: Shorter delays work as described here. If the read clear follows the write clear by k cycles, or the read side pauses for k cycles while writing goes on, `pix_1l` returns the word written at the same address one pass of the write counter earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| wr_clr_n | input | 1 | Write address clear, active low |
| wr_hold_n | input | 1 | Write step enable, active low |
| wr_pix | input | W | Pixel to store |
| rd_clk | input | 1 | Read clock, independent of wr_clk |
| rd_clr_n | input | 1 | Read address clear, active low |
| rd_hold_n | input | 1 | Read step enable, active low |
| pix_1l | output | W | Pixel one line back |
| pix_2l | output | W | Pixel two lines back |
| pix_vld | output | 1 | Output data valid |

## Verification
A 16-word configuration is driven through several distinct patterns:
- Several lines stream through with both sides running in step, using no clear between lines. This checks the one-line and two-line relation and the counter wrap.
- Write pauses during a read stream shorten the delay, which separates holding from stepping.
- A read pause with no writes is compared against a read pause with writes. This separates the guard interval from ordinary re-enabling.
- Clear pulses are offset by a few cycles. This checks that each clear restarts its own counter alone.

In every cycle, the expected data and valid flag come from a per-address model of both banks.

// File: rtl/lb2_pkg.sv
package lb2_pkg;
   // advance a line address, folding back to zero after the last word
   function automatic int unsigned lb2_next(input int unsigned a, input int unsigned depth);
      return (a == depth - 1) ? 0 : a + 1;
   endfunction
endpackage

// File: rtl/lb2_addr_ctr.sv
module lb2_addr_ctr #(
   parameter int DEPTH = 5120,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          clr_n,
   input  logic          hold_n,
   output logic [AW-1:0] addr
);
   import lb2_pkg::*;

   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   always_ff @(posedge clk) begin
      if (!clr_n) begin
         addr <= '0;
      end else if (!hold_n) begin
         addr <= (addr == LAST) ? '0 : AW'(lb2_next(32'(addr), DEPTH));
      end
   end
endmodule

// File: rtl/lb2_dpram.sv
module lb2_dpram #(
   parameter int W     = 8,
   parameter int DEPTH = 5120,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          wclk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic          rclk,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);
   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge wclk) begin
      if (we) mem[waddr] <= wdata;
   end

   // registered read port; holds its word while not enabled
   always_ff @(posedge rclk) begin
      if (re) rdata <= mem[raddr];
   end
endmodule

// File: rtl/lb2_rd_valid.sv
module lb2_rd_valid #(
   parameter int GUARD = 2,
   parameter int SYNC  = 2
) (
   input  logic rclk,
   input  logic rclr_n,
   input  logic rhold_n,
   input  logic wtog,
   output logic vld,
   output logic guard_busy
);
   localparam int GW = $clog2(GUARD + 1);

   logic [SYNC-1:0] sq;
   logic            seen;
   logic            dirty;
   logic [GW-1:0]   gcnt;
   logic            chg;

   // bring the write-activity toggle into the read domain
   always_ff @(posedge rclk) begin
      sq   <= {sq[SYNC-2:0], wtog};
      seen <= sq[SYNC-1];
   end

   assign chg        = sq[SYNC-1] ^ seen;
   assign guard_busy = (gcnt != '0);

   always_ff @(posedge rclk) begin
      if (!rclr_n) begin
         vld   <= 1'b0;
         dirty <= 1'b0;
         gcnt  <= '0;
      end else if (rhold_n) begin
         vld <= 1'b0;
         if (chg) dirty <= 1'b1;
      end else if (gcnt != '0) begin
         vld  <= 1'b0;
         gcnt <= gcnt - 1'b1;
      end else if (dirty) begin
         vld   <= 1'b0;
         dirty <= 1'b0;
         gcnt  <= GW'(GUARD - 1);
      end else begin
         vld <= 1'b1;
      end
   end
endmodule

// File: rtl/lb2_line_delay.sv
module lb2_line_delay #(
   parameter int W     = 8,
   parameter int DEPTH = 5120,
   parameter int GUARD = 2,
   parameter int SYNC  = 2
) (
   input  logic         wr_clk,
   input  logic         wr_clr_n,
   input  logic         wr_hold_n,
   input  logic [W-1:0] wr_pix,
   input  logic         rd_clk,
   input  logic         rd_clr_n,
   input  logic         rd_hold_n,
   output logic [W-1:0] pix_1l,
   output logic [W-1:0] pix_2l,
   output logic         pix_vld
);
   localparam int AW = $clog2(DEPTH);

   generate
      if (W < 1)     begin : g_bad_w     $error("W must be at least 1");     end
      if (DEPTH < 2) begin : g_bad_depth $error("DEPTH must be at least 2"); end
      if (GUARD < 1) begin : g_bad_guard $error("GUARD must be at least 1"); end
      if (SYNC < 2)  begin : g_bad_sync  $error("SYNC must be at least 2");  end
   endgenerate

   logic [AW-1:0] waddr, raddr, pend_addr;
   logic          wr_go, rd_go, pend, wtog, guard_busy;

   assign wr_go = wr_clr_n & ~wr_hold_n;
   assign rd_go = rd_clr_n & ~rd_hold_n;

   lb2_addr_ctr #(.DEPTH(DEPTH), .AW(AW)) u_wctr (
      .clk(wr_clk), .clr_n(wr_clr_n), .hold_n(wr_hold_n), .addr(waddr));

   lb2_addr_ctr #(.DEPTH(DEPTH), .AW(AW)) u_rctr (
      .clk(rd_clk), .clr_n(rd_clr_n), .hold_n(rd_hold_n), .addr(raddr));

   // write-activity toggle, crossed into the read domain by the valid logic
   always_ff @(posedge wr_clk) begin
      if (!wr_clr_n)  wtog <= 1'b0;
      else if (wr_go) wtog <= ~wtog;
   end

   lb2_dpram #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_near (
      .wclk(wr_clk), .we(wr_go), .waddr(waddr), .wdata(wr_pix),
      .rclk(rd_clk), .re(rd_go), .raddr(raddr), .rdata(pix_1l));

   // the word just read from the near bank lands in the far bank one edge
   // later, at the address it came from; successive reads never share an address
   always_ff @(posedge rd_clk) begin
      pend      <= rd_go;
      pend_addr <= raddr;
   end

   lb2_dpram #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_far (
      .wclk(rd_clk), .we(pend), .waddr(pend_addr), .wdata(pix_1l),
      .rclk(rd_clk), .re(rd_go), .raddr(raddr), .rdata(pix_2l));

   lb2_rd_valid #(.GUARD(GUARD), .SYNC(SYNC)) u_vld (
      .rclk(rd_clk), .rclr_n(rd_clr_n), .rhold_n(rd_hold_n), .wtog(wtog),
      .vld(pix_vld), .guard_busy(guard_busy));
endmodule

// File: rtl/lb2_line_delay_chk.sv
module lb2_line_delay_chk #(
   parameter int W     = 8,
   parameter int DEPTH = 5120,
   parameter int AW    = $clog2(DEPTH)
) (
   input logic          wr_clk,
   input logic          wr_clr_n,
   input logic          wr_hold_n,
   input logic [AW-1:0] waddr,
   input logic          rd_clk,
   input logic          rd_clr_n,
   input logic          rd_hold_n,
   input logic [AW-1:0] raddr,
   input logic [W-1:0]  pix_1l,
   input logic [W-1:0]  pix_2l,
   input logic          pix_vld,
   input logic          guard_busy
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   logic w_armed = 1'b0;
   logic r_armed = 1'b0;

   always_ff @(posedge wr_clk) if (!wr_clr_n) w_armed <= 1'b1;
   always_ff @(posedge rd_clk) if (!rd_clr_n) r_armed <= 1'b1;

   p_wstep_r1: assert property (@(posedge wr_clk) disable iff (!w_armed)
      (wr_clr_n && !wr_hold_n) |=>
      waddr == (($past(waddr) == LAST) ? '0 : $past(waddr) + 1'b1));

   p_whold_r2: assert property (@(posedge wr_clk) disable iff (!w_armed)
      (wr_clr_n && wr_hold_n) |=> $stable(waddr));

   p_rstep_r3: assert property (@(posedge rd_clk) disable iff (!r_armed)
      (rd_clr_n && !rd_hold_n && raddr != LAST) |=> raddr == $past(raddr) + 1'b1);

   p_rhold_r4: assert property (@(posedge rd_clk) disable iff (!r_armed)
      (rd_clr_n && rd_hold_n) |=>
      (!pix_vld && $stable(raddr) && $stable(pix_1l) && $stable(pix_2l)));

   p_wclr_r5: assert property (@(posedge wr_clk) disable iff (!w_armed)
      !wr_clr_n |=> waddr == '0);

   p_rclr_r6: assert property (@(posedge rd_clk) disable iff (!r_armed)
      !rd_clr_n |=> (raddr == '0 && !pix_vld));

   p_rwrap_r7: assert property (@(posedge rd_clk) disable iff (!r_armed)
      (rd_clr_n && !rd_hold_n && raddr == LAST) |=> raddr == '0);

   p_guard_r8: assert property (@(posedge rd_clk) disable iff (!r_armed)
      (rd_clr_n && !rd_hold_n && guard_busy) |=> !pix_vld);
endmodule

bind lb2_line_delay lb2_line_delay_chk #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_chk (
   .wr_clk(wr_clk), .wr_clr_n(wr_clr_n), .wr_hold_n(wr_hold_n), .waddr(waddr),
   .rd_clk(rd_clk), .rd_clr_n(rd_clr_n), .rd_hold_n(rd_hold_n), .raddr(raddr),
   .pix_1l(pix_1l), .pix_2l(pix_2l), .pix_vld(pix_vld), .guard_busy(guard_busy));

// File: tb/lb2_line_delay_tb.sv
module lb2_line_delay_tb;
   localparam int PERIOD = 10;
   localparam int W      = 8;
   localparam int DEPTH  = 16;
   localparam int GUARD  = 2;

   logic         wr_clk = 1'b0, rd_clk = 1'b0;
   logic         wr_clr_n, wr_hold_n, rd_clr_n, rd_hold_n;
   logic [W-1:0] wr_pix;
   logic [W-1:0] pix_1l, pix_2l;
   logic         pix_vld;

   int n_chk = 0, n_fail = 0;

   lb2_line_delay #(.W(W), .DEPTH(DEPTH), .GUARD(GUARD), .SYNC(2)) u_dut (
      .wr_clk(wr_clk), .wr_clr_n(wr_clr_n), .wr_hold_n(wr_hold_n), .wr_pix(wr_pix),
      .rd_clk(rd_clk), .rd_clr_n(rd_clr_n), .rd_hold_n(rd_hold_n),
      .pix_1l(pix_1l), .pix_2l(pix_2l), .pix_vld(pix_vld));

   // read edges at 5,15,...; write edges 3 units later
   initial forever #(PERIOD/2) rd_clk = ~rd_clk;
   initial begin #3; forever #(PERIOD/2) wr_clk = ~wr_clk; end

   // per-address model of both banks
   logic [W-1:0] m1 [DEPTH];
   logic [W-1:0] m2 [DEPTH];
   bit           k1 [DEPTH];
   bit           k2 [DEPTH];
   int           wa = 0, ra = 0, skip = 0;
   logic [W-1:0] e1 = '0, e2 = '0;
   bit           ek1 = 0, ek2 = 0, ev = 0;

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic step(input string req);
      @(posedge rd_clk);
      if (!rd_clr_n) begin
         ra = 0; ev = 0;                       // R6
      end else if (rd_hold_n) begin
         ev = 0;                               // R4: data hold
      end else begin                           // R3
         e1 = m1[ra]; ek1 = k1[ra];
         e2 = m2[ra]; ek2 = k2[ra];
         m2[ra] = m1[ra]; k2[ra] = k1[ra];
         ra = (ra == DEPTH-1) ? 0 : ra + 1;    // R7
         if (skip > 0) begin ev = 0; skip--; end else ev = 1;
      end
      #5;
      chk(req, "pix_vld", int'(pix_vld), int'(ev));
      if (ek1) chk(req, "pix_1l", int'(pix_1l), int'(e1));
      if (ek2) chk(req, "pix_2l", int'(pix_2l), int'(e2));
      if (!wr_clr_n) wa = 0;                   // R5
      else if (!wr_hold_n) begin               // R1
         m1[wa] = wr_pix; k1[wa] = 1;
         wa = (wa == DEPTH-1) ? 0 : wa + 1;
      end
   endtask

   task automatic run(input string req, input int n, input int seed);
      for (int i = 0; i < n; i++) begin
         wr_pix = W'(i * 29 + seed * 7 + 11);
         step(req);
      end
   endtask

   initial begin
      #(PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      for (int a = 0; a < DEPTH; a++) begin k1[a] = 0; k2[a] = 0; end
      wr_clr_n = 0; rd_clr_n = 0; wr_hold_n = 1; rd_hold_n = 1; wr_pix = '0;
      #1;
      run("R6", 3, 0);                          // reset state: not valid
      // R3 / R7: five lines in step, counters wrap on their own
      wr_clr_n = 1; rd_clr_n = 1; wr_hold_n = 0; rd_hold_n = 0;
      run("R3", DEPTH * 5, 1);
      // R2: write pauses while reading continues, garbage on the input
      wr_hold_n = 1; run("R2", 4, 9);
      wr_hold_n = 0; run("R2", DEPTH * 2, 2);
      // R9: quiet write side, then a read pause with no writes
      wr_hold_n = 1; run("R2", 4, 3);
      rd_hold_n = 1; run("R4", 5, 4);
      rd_hold_n = 0; run("R9", 1, 4);
      wr_hold_n = 0; run("R9", DEPTH, 5);
      // R8: read pause while writes go on, then the guard interval
      rd_hold_n = 1; run("R4", 8, 6);
      rd_hold_n = 0; skip = GUARD;
      run("R8", DEPTH * 2, 7);
      // R5 / R6 / R10: clears offset by four cycles
      wr_clr_n = 0; run("R5", 1, 8);
      wr_clr_n = 1; run("R10", 3, 8);
      rd_clr_n = 0; run("R6", 1, 8);
      rd_clr_n = 1; run("R10", DEPTH * 3, 10);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule